// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the device side of a single-bank NOR flash, meant to act as a memory target inside a chip. Every 16-bit write on its bus is read either as a command byte or as a data word. The meaning depends on what the state machine expects at that moment. A read returns an array word or the status byte, depending on the current read mode. The array is a small register memory divided into equal blocks.

Program and erase take a configurable number of busy cycles. An erase can be suspended and later resumed, and the remaining erase time is kept across the suspension. Each block has a lock bit. A locked block refuses program and erase. Command bytes are taken from the low byte of the write data. A program data word uses all 16 bits.

The bus has no back-pressure. Every write is taken in the cycle it is presented. A write that is not legal in the current state is dropped. Reads are combinational from the registered state.

Top module: `flash_cmd_sm`

## Requirements
- R1: After reset the read mode is array and every array word reads 0xFFFF. The status byte reads 0x80 and all blocks are locked.
- R2: Writing 0x70 selects status mode, in which the read data is {8'h00, status}. Writing 0xFF selects array mode, in which the read data is the word at the bus address.
- R3: A write of 0x40 followed by a data write to an unlocked block stores old AND data at that address. Ready is low for exactly PROG_CYCLES cycles after the data write. The block is left in status mode.
- R4: A write of 0x20 followed by 0xD0 to an unlocked block keeps ready low for ERASE_CYCLES active cycles. It then sets every word of that block to 0xFFFF and leaves other blocks unchanged.
- R5: Status byte layout: bit 7 is ready (0 while busy), bit 6 is erase suspended, bit 5 is erase error, bit 4 is program error, bit 1 is locked-block error. Bits 3, 2 and 0 are 0.
- R6: A write of 0x60 followed by 0xD0 unlocks the addressed block. A write of 0x60 followed by 0x01 locks it.
- R7: A program or erase aimed at a locked block sets bit 1 plus bit 4 (program) or bit 5 (erase). It starts no busy period and leaves the array unchanged.
- R8: A confirm byte other than the expected one after 0x20 or 0x60 sets bits 5 and 4. It starts nothing and leaves the block in status mode.
- R9: Writing 0x50 while idle or suspended clears bits 5, 4 and 1.
- R10: A write of 0xB0 during an erase sets bit 6 and bit 7 after SUSP_LAT further cycles. While suspended, array reads are served. A write of 0xD0 resumes the erase with its remaining cycles, so the erase totals ERASE_CYCLES active cycles.
- R11: If the erase finishes within the suspend latency, it completes normally and bit 6 never rises.
- R12: While a program is busy, writes other than 0xFF and 0x70 are dropped. While suspended, writes other than 0xD0, 0xFF, 0x70 and 0x50 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address for reads and writes; the upper BLK_W bits pick the block |
| bus_wdata | input | 16 | Write data: command in bits 7:0, or a program word |
| bus_rdata | output | 16 | Array word or zero-extended status byte |

## Verification
Several properties are checked on every cycle:
- a suspended erase always reports ready;
- the cycle after a finished countdown always reports ready;
- ready only rises on completion or on entry to suspend;
- the array never programs or erases a block whose lock bit is set.

The bench scenarios have to show the rest:
- the exact busy lengths, including the count across a suspension;
- the AND rule for programming;
- the error codes for locked blocks and bad confirm bytes;
- the dropping of illegal commands in the busy and suspended states;
- the case where the erase ends inside the suspend latency.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_LOCKSET = 8'h60;
  localparam logic [7:0] CMD_LOCKON  = 8'h01;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG_SETUP,
    S_ERASE_SETUP,
    S_LOCK_SETUP,
    S_PROG_BUSY,
    S_ERASE_BUSY,
    S_SUSP_WAIT,
    S_ERASE_SUSP
  } fsm_state_t;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - CNT_W'(1);
  end

  assign done = run && (cnt == CNT_W'(1));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int ADDR_W          = 5,
  parameter int BLK_W           = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [15:0]           rd_data,
  input  logic                  prog_en,
  input  logic [ADDR_W-1:0]     prog_addr,
  input  logic [15:0]           prog_data,
  input  logic                  erase_en,
  input  logic [BLK_W-1:0]      erase_blk,
  input  logic                  lock_set,
  input  logic                  lock_clr,
  input  logic [BLK_W-1:0]      lock_blk,
  output logic [NUM_BLOCKS-1:0] lock_vec
);
  localparam int DEPTH = NUM_BLOCKS * WORDS_PER_BLOCK;

  logic [15:0]           mem [DEPTH];
  logic [NUM_BLOCKS-1:0] erase_hit;
  logic [NUM_BLOCKS-1:0] lock_hit;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign erase_hit[b] = erase_en && (erase_blk == BLK_W'(b));
    assign lock_hit[b]  = lock_blk == BLK_W'(b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_hit[i / WORDS_PER_BLOCK])
          mem[i] <= 16'hFFFF;
        else if (prog_en && prog_addr == ADDR_W'(i))
          mem[i] <= mem[i] & prog_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_vec <= '1;
    else if (lock_set) lock_vec <= lock_vec | lock_hit;
    else if (lock_clr) lock_vec <= lock_vec & ~lock_hit;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int ADDR_W       = 5,
  parameter int BLK_W        = 2,
  parameter int CNT_W        = 5,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 20,
  parameter int SUSP_LAT     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [15:0]           bus_wdata,
  input  logic [NUM_BLOCKS-1:0] lock_vec,
  input  logic                  tmr_done,
  output logic                  tmr_load,
  output logic [CNT_W-1:0]      tmr_val,
  output logic                  tmr_run,
  output logic                  prog_en,
  output logic                  erase_en,
  output logic [ADDR_W-1:0]     op_addr,
  output logic [15:0]           op_data,
  output logic                  lock_set,
  output logic                  lock_clr,
  output logic [7:0]            status,
  output logic                  show_status
);
  localparam int LAT_W = $clog2(SUSP_LAT + 1);

  fsm_state_t        state, state_nx;
  logic [LAT_W-1:0]  lat_cnt;
  logic              err_p, err_e, err_l;
  logic [7:0]        cmd;
  logic              blk_locked, in_setup, is_confirm;
  logic              prog_go, prog_lockerr, erase_go, erase_lockerr, seq_err;
  logic              susp_req, resume, mode_wr, to_status, clr_err;

  assign cmd        = bus_wdata[7:0];
  assign blk_locked = lock_vec[bus_addr[ADDR_W-1 -: BLK_W]];
  assign is_confirm = cmd == CMD_CONFIRM;
  assign in_setup   = state inside {S_PROG_SETUP, S_ERASE_SETUP, S_LOCK_SETUP};

  assign prog_go       = bus_we && state == S_PROG_SETUP && !blk_locked;
  assign prog_lockerr  = bus_we && state == S_PROG_SETUP && blk_locked;
  assign erase_go      = bus_we && state == S_ERASE_SETUP && is_confirm && !blk_locked;
  assign erase_lockerr = bus_we && state == S_ERASE_SETUP && is_confirm && blk_locked;
  assign seq_err       = bus_we && ((state == S_ERASE_SETUP && !is_confirm) ||
                                    (state == S_LOCK_SETUP && !is_confirm && cmd != CMD_LOCKON));
  assign lock_clr      = bus_we && state == S_LOCK_SETUP && is_confirm;
  assign lock_set      = bus_we && state == S_LOCK_SETUP && cmd == CMD_LOCKON;

  assign tmr_run  = state inside {S_PROG_BUSY, S_ERASE_BUSY, S_SUSP_WAIT};
  assign tmr_load = prog_go || erase_go;
  assign tmr_val  = prog_go ? CNT_W'(PROG_CYCLES) : CNT_W'(ERASE_CYCLES);
  assign prog_en  = state == S_PROG_BUSY && tmr_done;
  assign erase_en = (state == S_ERASE_BUSY || state == S_SUSP_WAIT) && tmr_done;

  assign susp_req  = bus_we && state == S_ERASE_BUSY && cmd == CMD_SUSPEND && !tmr_done;
  assign resume    = bus_we && state == S_ERASE_SUSP && is_confirm;
  assign mode_wr   = bus_we && !in_setup && (cmd == CMD_ARRAY || cmd == CMD_STATUS);
  assign clr_err   = bus_we && cmd == CMD_CLEAR && (state == S_IDLE || state == S_ERASE_SUSP);
  assign to_status = resume || (bus_we && state == S_IDLE &&
                     (cmd == CMD_PROG || cmd == CMD_ERASE || cmd == CMD_LOCKSET));

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:
        if (bus_we) begin
          if (cmd == CMD_PROG)         state_nx = S_PROG_SETUP;
          else if (cmd == CMD_ERASE)   state_nx = S_ERASE_SETUP;
          else if (cmd == CMD_LOCKSET) state_nx = S_LOCK_SETUP;
        end
      S_PROG_SETUP:  if (bus_we) state_nx = prog_go ? S_PROG_BUSY : S_IDLE;
      S_ERASE_SETUP: if (bus_we) state_nx = erase_go ? S_ERASE_BUSY : S_IDLE;
      S_LOCK_SETUP:  if (bus_we) state_nx = S_IDLE;
      S_PROG_BUSY:   if (tmr_done) state_nx = S_IDLE;
      S_ERASE_BUSY:
        if (tmr_done)      state_nx = S_IDLE;
        else if (susp_req) state_nx = S_SUSP_WAIT;
      S_SUSP_WAIT:
        if (tmr_done)                      state_nx = S_IDLE;
        else if (lat_cnt == LAT_W'(1))     state_nx = S_ERASE_SUSP;
      S_ERASE_SUSP:  if (resume) state_nx = S_ERASE_BUSY;
      default:       state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      show_status <= 1'b0;
      err_p       <= 1'b0;
      err_e       <= 1'b0;
      err_l       <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
      lat_cnt     <= '0;
    end else begin
      state <= state_nx;
      if (mode_wr)        show_status <= (cmd == CMD_STATUS);
      else if (to_status) show_status <= 1'b1;
      if (clr_err) begin
        err_p <= 1'b0;
        err_e <= 1'b0;
        err_l <= 1'b0;
      end else begin
        if (prog_lockerr || seq_err)          err_p <= 1'b1;
        if (erase_lockerr || seq_err)         err_e <= 1'b1;
        if (prog_lockerr || erase_lockerr)    err_l <= 1'b1;
      end
      if (prog_go || erase_go) begin
        op_addr <= bus_addr;
        op_data <= bus_wdata;
      end
      if (susp_req)                 lat_cnt <= LAT_W'(SUSP_LAT);
      else if (state == S_SUSP_WAIT) lat_cnt <= lat_cnt - LAT_W'(1);
    end
  end

  assign status = {!tmr_run, state == S_ERASE_SUSP, err_e, err_p, 2'b00, err_l, 1'b0};
endmodule

// File: rtl/flash_cmd_sm.sv
module flash_cmd_sm #(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int PROG_CYCLES     = 4,
  parameter int ERASE_CYCLES    = 20,
  parameter int SUSP_LAT        = 2,
  parameter int ADDR_W_P        = $clog2(NUM_BLOCKS * WORDS_PER_BLOCK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W_P-1:0] bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata
);
  localparam int ADDR_W = ADDR_W_P;
  localparam int BLK_W  = $clog2(NUM_BLOCKS);
  localparam int MAXC   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W  = $clog2(MAXC + 1);

  logic [NUM_BLOCKS-1:0] lock_vec;
  logic                  tmr_load, tmr_run, tmr_done;
  logic [CNT_W-1:0]      tmr_val;
  logic                  prog_en, erase_en, lock_set, lock_clr, show_status;
  logic [ADDR_W-1:0]     op_addr;
  logic [15:0]           op_data, arr_rd;
  logic [7:0]            status;

  flash_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .SUSP_LAT(SUSP_LAT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .lock_vec(lock_vec), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_run(tmr_run),
    .prog_en(prog_en), .erase_en(erase_en), .op_addr(op_addr), .op_data(op_data),
    .lock_set(lock_set), .lock_clr(lock_clr), .status(status),
    .show_status(show_status)
  );

  flash_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .done(tmr_done)
  );

  flash_array #(
    .NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
    .ADDR_W(ADDR_W), .BLK_W(BLK_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .rd_data(arr_rd),
    .prog_en(prog_en), .prog_addr(op_addr), .prog_data(op_data),
    .erase_en(erase_en), .erase_blk(op_addr[ADDR_W-1 -: BLK_W]),
    .lock_set(lock_set), .lock_clr(lock_clr),
    .lock_blk(bus_addr[ADDR_W-1 -: BLK_W]), .lock_vec(lock_vec)
  );

  assign bus_rdata = show_status ? {8'h00, status} : arr_rd;
endmodule

// File: rtl/flash_cmd_sm_checker.sv
module flash_cmd_sm_checker #(
  parameter int NUM_BLOCKS = 4,
  parameter int ADDR_W     = 5,
  parameter int BLK_W      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [7:0]            status,
  input logic                  tmr_done,
  input logic                  prog_en,
  input logic                  erase_en,
  input logic [ADDR_W-1:0]     op_addr,
  input logic [NUM_BLOCKS-1:0] lock_vec
);
  logic [BLK_W-1:0] op_blk;
  assign op_blk = op_addr[ADDR_W-1 -: BLK_W];

  assert_susp_is_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[7]);

  assert_done_gives_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |=> status[7]);

  assert_ready_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> ($past(tmr_done) || status[6]));

  assert_susp_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> !$past(status[7]));

  assert_prog_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> !lock_vec[op_blk]);

  assert_erase_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |-> !lock_vec[op_blk]);
endmodule

bind flash_cmd_sm flash_cmd_sm_checker #(
  .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .BLK_W(BLK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .tmr_done(tmr_done),
  .prog_en(prog_en), .erase_en(erase_en), .op_addr(op_addr), .lock_vec(lock_vec)
);

// File: tb/flash_cmd_sm_test.sv
module flash_cmd_sm_test;
  localparam int PROG_C  = 4;
  localparam int ERASE_C = 20;
  localparam int LAT     = 2;

  typedef struct packed {
    logic        rd;
    logic [4:0]  addr;
    logic [15:0] data;
    logic [3:0]  req;
  } vec_t;

  // rd=0: bus write of data; rd=1: read and compare with data
  localparam vec_t VEC [30] = '{
    '{1'b1, 5'd0,  16'hFFFF, 4'd1},  // R1 erased array, array mode
    '{1'b0, 5'd0,  16'h0070, 4'd0},
    '{1'b1, 5'd0,  16'h0080, 4'd2},  // R2 status mode, idle status
    '{1'b0, 5'd3,  16'h0040, 4'd0},
    '{1'b0, 5'd3,  16'h1234, 4'd0},
    '{1'b1, 5'd0,  16'h0092, 4'd7},  // R7 program to locked block
    '{1'b0, 5'd0,  16'h0050, 4'd0},
    '{1'b1, 5'd0,  16'h0080, 4'd9},  // R9 clear
    '{1'b0, 5'd0,  16'h0060, 4'd0},
    '{1'b0, 5'd0,  16'h00D0, 4'd0},
    '{1'b1, 5'd0,  16'h0080, 4'd6},  // R6 unlock block 0
    '{1'b0, 5'd8,  16'h0020, 4'd0},
    '{1'b0, 5'd8,  16'h00D0, 4'd0},
    '{1'b1, 5'd0,  16'h00A2, 4'd7},  // R7 erase of locked block
    '{1'b0, 5'd0,  16'h0050, 4'd0},
    '{1'b0, 5'd0,  16'h0060, 4'd0},
    '{1'b0, 5'd0,  16'h0033, 4'd0},
    '{1'b1, 5'd0,  16'h00B0, 4'd8},  // R8 bad confirm
    '{1'b0, 5'd0,  16'h0050, 4'd0},
    '{1'b0, 5'd0,  16'h00FF, 4'd0},
    '{1'b1, 5'd5,  16'hFFFF, 4'd2},  // R2 back to array mode
    '{1'b0, 5'd0,  16'h0060, 4'd0},
    '{1'b0, 5'd0,  16'h0001, 4'd0},
    '{1'b0, 5'd2,  16'h0040, 4'd0},
    '{1'b0, 5'd2,  16'h0000, 4'd0},
    '{1'b1, 5'd0,  16'h0092, 4'd6},  // R6 relocked block refuses program
    '{1'b0, 5'd0,  16'h0050, 4'd0},
    '{1'b0, 5'd0,  16'h0060, 4'd0},
    '{1'b0, 5'd0,  16'h00D0, 4'd0},
    '{1'b1, 5'd0,  16'h0080, 4'd6}   // R6 unlocked again
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_sm uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic expect_val(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    #1;
    while (!bus_rdata[7] && n < 1000) begin
      @(negedge clk);
      #1;
      n++;
    end
    @(negedge clk);
    n = n;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      if (VEC[i].rd) expect_rd(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec%0d", VEC[i].req, i));
      else begin
        wr(VEC[i].addr, VEC[i].data);
      end
    end
    @(negedge clk);

    // R3 / R5: program timing, auto status, AND rule
    wr(5'd0, 16'h0070);
    wr(5'd2, 16'h0040);
    wr(5'd2, 16'h5A5A);
    expect_rd(5'd0, 16'h0000, "R5 busy status");
    wait_ready(n);
    expect_val(n, PROG_C, "R3 program busy length");
    expect_rd(5'd0, 16'h0080, "R3 status mode after program");
    wr(5'd0, 16'h00FF);
    expect_rd(5'd2, 16'h5A5A, "R3 programmed word");
    wr(5'd2, 16'h0040);
    wr(5'd2, 16'h0FF0);
    wait_ready(n);
    wr(5'd0, 16'h00FF);
    expect_rd(5'd2, 16'h0A50, "R3 program only clears bits");

    // R12: command during program busy is dropped
    wr(5'd4, 16'h0040);
    wr(5'd4, 16'h00F0);
    wr(5'd4, 16'h0020);
    wait_ready(n);
    wr(5'd4, 16'h00D0);
    expect_rd(5'd0, 16'h0080, "R12 erase setup dropped while busy");
    wr(5'd0, 16'h00FF);
    expect_rd(5'd4, 16'h00F0, "R12 array after dropped command");

    // R4: erase length, block contents, neighbour block intact
    wr(5'd8, 16'h0060);
    wr(5'd8, 16'h00D0);
    wr(5'd9, 16'h0040);
    wr(5'd9, 16'h1111);
    wait_ready(n);
    wr(5'd0, 16'h0020);
    wr(5'd0, 16'h00D0);
    expect_rd(5'd0, 16'h0000, "R4 busy during erase");
    wait_ready(n);
    expect_val(n, ERASE_C, "R4 erase busy length");
    wr(5'd0, 16'h00FF);
    expect_rd(5'd2, 16'hFFFF, "R4 erased word 2");
    expect_rd(5'd4, 16'hFFFF, "R4 erased word 4");
    expect_rd(5'd9, 16'h1111, "R4 other block untouched");

    // R10: suspend and resume
    wr(5'd1, 16'h0040);
    wr(5'd1, 16'h0000);
    wait_ready(n);
    wr(5'd0, 16'h0020);
    wr(5'd0, 16'h00D0);
    repeat (5) @(negedge clk);
    wr(5'd0, 16'h00B0);
    expect_rd(5'd0, 16'h0000, "R10 suspend latency cycle 0");
    @(negedge clk);
    expect_rd(5'd0, 16'h0000, "R10 suspend latency cycle 1");
    @(negedge clk);
    expect_rd(5'd0, 16'h00C0, "R10 suspended status");
    wr(5'd0, 16'h0040);
    wr(5'd0, 16'h00FF);
    expect_rd(5'd1, 16'h0000, "R10 array read while suspended");
    wr(5'd0, 16'h0070);
    expect_rd(5'd0, 16'h00C0, "R12 program setup dropped while suspended");
    wr(5'd0, 16'h00D0);
    expect_rd(5'd0, 16'h0000, "R10 busy after resume");
    wait_ready(n);
    expect_val(n, ERASE_C - 5 - 1 - LAT, "R10 remaining erase cycles");
    wr(5'd0, 16'h00FF);
    expect_rd(5'd1, 16'hFFFF, "R10 erase finished after resume");

    // R11: erase ends inside the suspend latency
    wr(5'd1, 16'h0040);
    wr(5'd1, 16'h0000);
    wait_ready(n);
    wr(5'd0, 16'h0020);
    wr(5'd0, 16'h00D0);
    repeat (ERASE_C - 2) @(negedge clk);
    wr(5'd0, 16'h00B0);
    expect_rd(5'd0, 16'h0000, "R11 still busy");
    @(negedge clk);
    expect_rd(5'd0, 16'h0080, "R11 done without suspend bit");
    wr(5'd0, 16'h00FF);
    expect_rd(5'd1, 16'hFFFF, "R11 block erased");

    // R1: reset mid-run restores array, mode and locks
    wr(5'd10, 16'h0040);
    wr(5'd10, 16'h2222);
    wait_ready(n);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_rd(5'd10, 16'hFFFF, "R1 array and mode after reset");
    wr(5'd10, 16'h0040);
    wr(5'd10, 16'h0000);
    expect_rd(5'd0, 16'h0092, "R1 blocks locked after reset");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule